// File: doc/BRIEF.md
# Interleaved MSI Interrupt Aggregator

This block collects message-signalled interrupts for a PCIe root complex. An inbound memory write to the doorbell offset carries a vector number from 0 to 31. The vector raises one pending bit, and the 32 pending bits are spread over eight groups of four. Each group owns one host interrupt line. The spreading is interleaved: consecutive vectors land in consecutive groups, so vectors 0 to 7 each take bit 0 of a different group, and vector 8 wraps back to group 0 at bit 1.

Software reaches the block through a simple 32-bit register port. For each group there are three registers: pending status (write-1-to-clear), enable-set and enable-clear. A shared end-of-interrupt register takes a code for each source. Codes 4 to 11 acknowledge MSI groups 0 to 7. Codes 0 to 3 are reserved for other interrupt sources and have no effect here. Acknowledging a group drops its line for one cycle, so a downstream edge-sensitive controller sees a fresh edge when enabled work is still pending.

Top module: `msi_interleave_agg`

## Requirements
- R1: After reset, every status and enable bit reads zero and all eight interrupt lines are low.
- R2: An inbound write to offset 0x054 takes the vector v from data bits 4:0 and ignores higher bits. It sets status bit v>>3 of group v mod 8 one cycle later. An inbound write to any other offset changes nothing.
- R3: The status of group n reads at 0x104+16n, with bits 3:0 holding the pending bits and bits 31:4 reading zero. Writing ones there clears exactly those bits.
- R4: Writing ones to 0x108+16n enables those bits of group n. Writing ones to 0x10C+16n disables them. Other enable bits keep their values. A read of either address returns the enable mask of group n in bits 3:0.
- R5: Interrupt line n is high exactly when some bit of group n is both pending and enabled, except in the cycle after an acknowledge of group n.
- R6: If a doorbell write and a status clear hit the same bit in the same cycle, the bit ends up set. A clear of a different bit in that cycle still takes effect.
- R7: Writing n+4 to the end-of-interrupt register at 0x050 holds line n low for the next cycle. The line then returns high if an enabled bit of group n is still pending. The status bits are not changed.
- R8: End-of-interrupt codes 0 to 3 and codes above 11 leave every interrupt line unchanged.
- R9: A register read of any offset that is not a status or enable register returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| in_wr | input | 1 | Inbound write strobe |
| in_addr | input | 12 | Inbound write byte offset |
| in_data | input | 32 | Inbound write data, vector in bits 4:0 |
| irq | output | 8 | One interrupt line per group |

## Verification
Every one of the 32 vectors is rung with junk in the upper data bits. All eight status registers are then read back. This pins down the interleaved group and bit mapping and shows that each vector touches only its own bit. A second sweep rings all vectors under a partial enable pattern that differs per group. Comparing all eight lines with an arithmetic model separates gating by enable from gating by pending.

Acknowledge codes are tried across the reserved, valid and out-of-range values. For a valid code, the one-cycle drop is checked, followed by re-assertion while work remains pending and no re-assertion once the group is cleared. A same-cycle doorbell and clear on the same bit, and on different bits, distinguishes set priority from a blanket hold.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int GROUPS   = 8;
    localparam int GBITS    = 4;
    localparam int VECTORS  = GROUPS * GBITS;
    localparam int VEC_W    = $clog2(VECTORS);
    localparam int GRP_W    = $clog2(GROUPS);
    localparam int BIT_W    = $clog2(GBITS);
    localparam int STRIDE_W = 4;

    localparam logic [ADDR_W-1:0] DOORBELL_OFS = 12'h054;
    localparam logic [ADDR_W-1:0] ACK_OFS      = 12'h050;
    localparam logic [ADDR_W-1:0] GRP_BASE     = 12'h100;
    localparam logic [ADDR_W-1:0] GRP_END      = GRP_BASE + ADDR_W'(GROUPS << STRIDE_W);
    localparam int                ACK_MSI_BASE = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_ACK
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e        kind;
        logic [GRP_W-1:0] grp;
    } reg_sel_t;

    typedef struct packed {
        logic [GRP_W-1:0] grp;
        logic [BIT_W-1:0] pos;
    } vec_route_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t          s;
        logic [ADDR_W-1:0] off;
        s.kind = SEL_NONE;
        off    = a - GRP_BASE;
        s.grp  = off[STRIDE_W +: GRP_W];
        if (a == ACK_OFS) begin
            s.kind = SEL_ACK;
        end else if (a >= GRP_BASE && a < GRP_END) begin
            case (off[STRIDE_W-1:0])
                4'h4:    s.kind = SEL_PEND;
                4'h8:    s.kind = SEL_EN_SET;
                4'hC:    s.kind = SEL_EN_CLR;
                default: s.kind = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic vec_route_t route_vector(input logic [VEC_W-1:0] v);
        vec_route_t r;
        r.grp = v[GRP_W-1:0];
        r.pos = v[VEC_W-1:GRP_W];
        return r;
    endfunction

endpackage

// File: rtl/msi_inbound_router.sv
module msi_inbound_router
    import msi_agg_pkg::*;
(
    input  logic              in_wr,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic [VECTORS-1:0] set_flat
);
    vec_route_t route;
    logic       unused_in_hi;

    assign route        = route_vector(in_data[VEC_W-1:0]);
    assign unused_in_hi = ^in_data[DATA_W-1:VEC_W];

    always_comb begin
        set_flat = '0;
        if (in_wr && in_addr == DOORBELL_OFS)
            set_flat[{route.grp, route.pos}] = 1'b1;
    end
endmodule

// File: rtl/msi_group.sv
module msi_group #(
    parameter int NBITS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NBITS-1:0] set_bits,
    input  logic [NBITS-1:0] clr_bits,
    input  logic [NBITS-1:0] en_on,
    input  logic [NBITS-1:0] en_off,
    input  logic             ack,
    output logic [NBITS-1:0] pend,
    output logic [NBITS-1:0] en,
    output logic             line
);
    logic ack_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            en       <= '0;
            ack_hold <= 1'b0;
        end else begin
            pend     <= (pend & ~clr_bits) | set_bits;
            en       <= (en | en_on) & ~en_off;
            ack_hold <= ack;
        end
    end

    assign line = (|(pend & en)) && !ack_hold;
endmodule

// File: rtl/msi_read_mux.sv
module msi_read_mux
    import msi_agg_pkg::*;
(
    input  reg_sel_t           sel,
    input  logic [VECTORS-1:0] pend_flat,
    input  logic [VECTORS-1:0] en_flat,
    output logic [DATA_W-1:0]  rdata
);
    always_comb begin
        rdata = '0;
        case (sel.kind)
            SEL_PEND:               rdata[GBITS-1:0] = pend_flat[sel.grp*GBITS +: GBITS];
            SEL_EN_SET, SEL_EN_CLR: rdata[GBITS-1:0] = en_flat[sel.grp*GBITS +: GBITS];
            default:                rdata = '0;
        endcase
    end
endmodule

// File: rtl/msi_interleave_agg.sv
module msi_interleave_agg
    import msi_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [11:0]       cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              in_wr,
    input  logic [11:0]       in_addr,
    input  logic [31:0]       in_data,
    output logic [7:0]        irq
);
    reg_sel_t           sel;
    logic [VECTORS-1:0] set_flat;
    logic [VECTORS-1:0] status_all;
    logic [VECTORS-1:0] enable_all;

    assign sel = decode_addr(cfg_addr);

    msi_inbound_router i_router (
        .in_wr    (in_wr),
        .in_addr  (in_addr),
        .in_data  (in_data),
        .set_flat (set_flat)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic             hit;
        logic [GBITS-1:0] clr_bits, en_on, en_off;
        logic             ack;

        assign hit      = cfg_wr && (sel.grp == GRP_W'(g));
        assign clr_bits = (hit && sel.kind == SEL_PEND)   ? cfg_wdata[GBITS-1:0] : '0;
        assign en_on    = (hit && sel.kind == SEL_EN_SET) ? cfg_wdata[GBITS-1:0] : '0;
        assign en_off   = (hit && sel.kind == SEL_EN_CLR) ? cfg_wdata[GBITS-1:0] : '0;
        assign ack      = cfg_wr && sel.kind == SEL_ACK
                          && cfg_wdata == DATA_W'(g + ACK_MSI_BASE);

        msi_group #(.NBITS(GBITS)) i_group (
            .clk      (clk),
            .rst      (rst),
            .set_bits (set_flat[g*GBITS +: GBITS]),
            .clr_bits (clr_bits),
            .en_on    (en_on),
            .en_off   (en_off),
            .ack      (ack),
            .pend     (status_all[g*GBITS +: GBITS]),
            .en       (enable_all[g*GBITS +: GBITS]),
            .line     (irq[g])
        );
    end

    msi_read_mux i_rmux (
        .sel       (sel),
        .pend_flat (status_all),
        .en_flat   (enable_all),
        .rdata     (cfg_rdata)
    );
endmodule

// File: rtl/msi_agg_checker.sv
module msi_agg_checker
    import msi_agg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               cfg_wr,
    input logic [11:0]        cfg_addr,
    input logic [31:0]        cfg_wdata,
    input logic               in_wr,
    input logic [11:0]        in_addr,
    input logic [31:0]        in_data,
    input logic [7:0]         irq,
    input logic [VECTORS-1:0] status_all,
    input logic [VECTORS-1:0] enable_all
);
    // R2: a doorbell lands in group v mod 8, bit v>>3
    p_doorbell_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (in_wr && in_addr == DOORBELL_OFS)
        |=> status_all[{$past(in_data[GRP_W-1:0]), $past(in_data[VEC_W-1:GRP_W])}]);

    // R2: without a doorbell no pending bit appears
    p_no_spurious_pend_r2: assert property (@(posedge clk) disable iff (rst)
        !in_wr |=> ((status_all & ~$past(status_all)) == '0));

    // R4: enables only move on a register write
    p_enable_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr |=> $stable(enable_all));

    for (genvar g = 0; g < GROUPS; g++) begin : g_chk
        // R5: a line never rises without enabled pending work
        p_line_needs_work_r5: assert property (@(posedge clk) disable iff (rst)
            irq[g] |-> |(status_all[g*GBITS +: GBITS] & enable_all[g*GBITS +: GBITS]));

        // R7: an acknowledge of this group drops its line next cycle
        p_ack_drops_r7: assert property (@(posedge clk) disable iff (rst)
            (cfg_wr && cfg_addr == ACK_OFS && cfg_wdata == 32'(g + ACK_MSI_BASE))
            |=> !irq[g]);
    end
endmodule

bind msi_interleave_agg msi_agg_checker i_msi_agg_checker (
    .clk        (clk),
    .rst        (rst),
    .cfg_wr     (cfg_wr),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .in_wr      (in_wr),
    .in_addr    (in_addr),
    .in_data    (in_data),
    .irq        (irq),
    .status_all (status_all),
    .enable_all (enable_all)
);

// File: tb/test_msi_interleave_agg.sv
`timescale 1ns/1ps
module test_msi_interleave_agg;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wr;
    logic [11:0] cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        in_wr;
    logic [11:0] in_addr;
    logic [31:0] in_data;
    logic [7:0]  irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] m_st [8];
    logic [3:0] m_en [8];

    always #2.5 clk = ~clk;

    msi_interleave_agg i_msi_interleave_agg (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_wr(in_wr),
        .in_addr(in_addr), .in_data(in_data), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_irq();
        logic [7:0] r;
        for (int g = 0; g < 8; g++) r[g] = |(m_st[g] & m_en[g]);
        return r;
    endfunction

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic ring(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        in_wr = 1'b1; in_addr = a; in_data = d;
        @(negedge clk);
        in_wr = 1'b0;
    endtask

    task automatic read_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
        cfg_addr = a;
        #0.5;
        chk(cfg_rdata == exp, req, cfg_rdata, exp);
    endtask

    task automatic chk_all_status(input string req);
        for (int g = 0; g < 8; g++)
            read_chk(12'h104 + 12'(16*g), {28'h0, m_st[g]}, req);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        in_wr = 1'b0; in_addr = '0; in_data = '0;
        for (int g = 0; g < 8; g++) begin m_st[g] = '0; m_en[g] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk_all_status("R1");
        for (int g = 0; g < 8; g++) read_chk(12'h108 + 12'(16*g), 32'h0, "R1");
        chk(irq == 8'h0, "R1", {24'h0, irq}, 32'h0);

        // R2/R3: sweep all vectors with junk above bit 4
        for (int v = 0; v < 32; v++) begin
            ring(12'h054, 32'hABCDEF00 | 32'(v) | 32'hE0);
            m_st[v % 8][v / 8] = 1'b1;
            chk_all_status("R2");
            chk(irq == 8'h0, "R5", {24'h0, irq}, 32'h0);
            reg_write(12'h104 + 12'(16*(v % 8)), 32'hFFFFFFF0 | (32'h1 << (v / 8)));
            m_st[v % 8][v / 8] = 1'b0;
            chk_all_status("R3");
        end

        // R2: inbound write to a different offset does nothing
        ring(12'h058, 32'h5);
        ring(12'h050, 32'h5);
        chk_all_status("R2");

        // R4: enable set/clear per group, read back through both addresses
        for (int g = 0; g < 8; g++) begin
            reg_write(12'h108 + 12'(16*g), 32'hF);
            reg_write(12'h10C + 12'(16*g), 32'(g % 4 + 1) | 32'hFFFFFFF0);
            m_en[g] = 4'hF & ~4'(g % 4 + 1);
            reg_write(12'h108 + 12'(16*g), 32'h0);
            read_chk(12'h108 + 12'(16*g), {28'h0, m_en[g]}, "R4");
            read_chk(12'h10C + 12'(16*g), {28'h0, m_en[g]}, "R4");
        end

        // R5: ring each vector, compare lines with model
        for (int v = 0; v < 32; v++) begin
            ring(12'h054, 32'(v));
            m_st[v % 8][v / 8] = 1'b1;
            chk(irq == model_irq(), "R5", {24'h0, irq}, {24'h0, model_irq()});
        end

        // R9: unused offsets read zero
        read_chk(12'h054, 32'h0, "R9");
        read_chk(12'h050, 32'h0, "R9");
        read_chk(12'h100, 32'h0, "R9");
        read_chk(12'h180, 32'h0, "R9");

        // R8: reserved and out-of-range acknowledge codes change no line
        for (int c = 0; c < 4; c++) begin
            reg_write(12'h050, 32'(c));
            chk(irq == model_irq(), "R8", {24'h0, irq}, {24'h0, model_irq()});
        end
        reg_write(12'h050, 32'd12);
        chk(irq == model_irq(), "R8", {24'h0, irq}, {24'h0, model_irq()});

        // R7: acknowledge each group: one-cycle drop, then re-assert
        for (int g = 0; g < 8; g++) begin
            reg_write(12'h050, 32'(g + 4));
            chk(irq == (model_irq() & ~(8'h1 << g)), "R7", {24'h0, irq}, {24'h0, model_irq() & ~(8'h1 << g)});
            @(negedge clk);
            chk(irq == model_irq(), "R7", {24'h0, irq}, {24'h0, model_irq()});
        end
        chk_all_status("R7");

        // R7: after clearing group 2, acknowledge leaves it low
        reg_write(12'h104 + 12'(32), 32'hF);
        m_st[2] = '0;
        reg_write(12'h050, 32'd6);
        @(negedge clk);
        chk(irq[2] == 1'b0, "R7", {31'h0, irq[2]}, 32'h0);

        // R6: doorbell and clear on the same bit in one cycle
        @(negedge clk);
        in_wr = 1'b1; in_addr = 12'h054; in_data = 32'd10;      // group 2 bit 1
        cfg_wr = 1'b1; cfg_addr = 12'h124; cfg_wdata = 32'h2;
        @(negedge clk);
        in_wr = 1'b0; cfg_wr = 1'b0;
        m_st[2][1] = 1'b1;
        read_chk(12'h124, {28'h0, m_st[2]}, "R6");

        // R6: doorbell on one bit, clear on another of the same group
        @(negedge clk);
        in_wr = 1'b1; in_addr = 12'h054; in_data = 32'd2;       // group 2 bit 0
        cfg_wr = 1'b1; cfg_addr = 12'h124; cfg_wdata = 32'h2;
        @(negedge clk);
        in_wr = 1'b0; cfg_wr = 1'b0;
        m_st[2] = 4'b0001;
        read_chk(12'h124, {28'h0, m_st[2]}, "R6");

        // R1: reset clears everything again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int g = 0; g < 8; g++) begin m_st[g] = '0; m_en[g] = '0; end
        chk_all_status("R1");
        chk(irq == 8'h0, "R1", {24'h0, irq}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule